// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Detection

This block is an eight-pin general-purpose I/O port that sits on a simple APB-style register bus. The bus carries 8-bit data. One register chooses the direction of each pin and drives that pin's output enable. The data path uses the address as a pin mask, so software can change or sample any subset of pins in a single access, without a read-modify-write.

Each pin can raise an interrupt. Three configuration bits per pin set how it is detected:

- a level/edge select,
- a both-edges override,
- a polarity bit.

Edge events are held in sticky status bits until software clears them by writing ones to a clear register. Level events track the sampled input directly. An enable register masks the raw status into the masked status, and a single interrupt line is the OR of all masked bits. Each pin input is registered once before it reaches the read path and the detectors.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0. `pin_oe`, `pin_out` and `irq_out` are all 0.
- R2: The direction register sits at offset 0x400. Bit n = 1 makes pin n an output, and `pin_oe` follows that register from the cycle after the write.
- R3: Offsets 0x000 to 0x3FC form the data window, and address bits [9:2] are the pin mask (bit 2 is pin 0).
  - A write changes only the output pins that are selected in the mask.
  - A read returns the driven value for output pins and the sampled input for input pins, with unselected bits read as 0.
- R4: A data write has no effect on a pin that is currently an input. If that pin later becomes an output, it drives its earlier value, not the ignored write.
- R5: Offset 0x404 selects the detection mode, with 1 for level and 0 for edge. For a level pin, the raw status equals the sampled input when the polarity bit is 1, and its inverse when the polarity bit is 0. While a pin is in level mode, no edge event is kept for it.
- R6: For an edge pin, offset 0x40C sets the polarity: 1 means rising and 0 means falling. A matching change on the sampled input sets a sticky raw-status bit, which reads at offset 0x414. That bit is visible from the second clock edge after the pin changes.
- R7: Offset 0x408 set to 1 makes both rising and falling edges trigger the pin, whatever its polarity bit says.
- R8: Writing ones to offset 0x41C clears the matching sticky edge bits. This has no lasting effect on level pins. If an edge arrives in the same cycle as its clear, the edge wins and the bit stays set.
- R9: Offset 0x410 is the enable register. Offset 0x418 reads raw status AND enable, and `irq_out` is the OR of those masked bits.
- R10: The direction, mode, both-edge, polarity and enable registers read back the value last written. The clear register and the unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected for a read |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is an edge that arrives in exactly the cycle in which software clears that pin's status.

The bench gets there by changing the pin in the same cycle as the setup phase of a clear write. The registered sample then forms its edge during the access phase, so the detected edge and the clear meet at one clock edge.

A second hard case is a data write aimed at input pins whose value must not reappear once they turn into outputs. Random sequences of direction changes and masked writes keep exercising that case against a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GPIO_W = 8;

    typedef enum logic [2:0] {
        RIDX_DIR    = 3'd0,
        RIDX_SENSE  = 3'd1,
        RIDX_BOTH   = 3'd2,
        RIDX_POLAR  = 3'd3,
        RIDX_ENABLE = 3'd4,
        RIDX_RAW    = 3'd5,
        RIDX_MASKED = 3'd6,
        RIDX_CLEAR  = 3'd7
    } reg_idx_t;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] sense;
        logic [GPIO_W-1:0] both;
        logic [GPIO_W-1:0] polar;
        logic [GPIO_W-1:0] enable;
        logic [GPIO_W-1:0] dout;
    } gpio_cfg_t;

    typedef struct packed {
        logic smp;
        logic prev;
        logic held;
    } edge_state_t;

endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [GPIO_W-1:0] pwdata,
    input  logic [GPIO_W-1:0] pin_sample,
    input  logic [GPIO_W-1:0] raw_stat,
    output gpio_cfg_t         cfg,
    output logic [GPIO_W-1:0] clr_pulse,
    output logic [GPIO_W-1:0] prdata
);

    localparam int HI_W = ADDR_W - 10;

    gpio_cfg_t         cfg_d, cfg_q;
    logic              acc_wr;
    logic              in_data;
    logic              in_ctrl;
    reg_idx_t          sel;
    logic [GPIO_W-1:0] pin_mask;
    logic [GPIO_W-1:0] rd_val;
    logic [GPIO_W-1:0] pin_view;

    always_comb begin
        acc_wr    = psel & penable & pwrite;
        in_data   = (paddr[ADDR_W-1:10] == HI_W'(0));
        in_ctrl   = (paddr[ADDR_W-1:10] == HI_W'(1)) && (paddr[9:5] == 5'd0);
        sel       = reg_idx_t'(paddr[4:2]);
        pin_mask  = paddr[GPIO_W+1:2];
        pin_view  = (cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & pin_sample);
        cfg_d     = cfg_q;
        clr_pulse = '0;
        rd_val    = '0;

        if (acc_wr && in_data) begin
            cfg_d.dout = (cfg_q.dout & ~(pin_mask & cfg_q.dir))
                       | (pwdata & pin_mask & cfg_q.dir);
        end
        if (acc_wr && in_ctrl) begin
            case (sel)
                RIDX_DIR:    cfg_d.dir    = pwdata;
                RIDX_SENSE:  cfg_d.sense  = pwdata;
                RIDX_BOTH:   cfg_d.both   = pwdata;
                RIDX_POLAR:  cfg_d.polar  = pwdata;
                RIDX_ENABLE: cfg_d.enable = pwdata;
                RIDX_CLEAR:  clr_pulse    = pwdata;
                default:     ;
            endcase
        end

        if (in_data) begin
            rd_val = pin_view & pin_mask;
        end else if (in_ctrl) begin
            case (sel)
                RIDX_DIR:    rd_val = cfg_q.dir;
                RIDX_SENSE:  rd_val = cfg_q.sense;
                RIDX_BOTH:   rd_val = cfg_q.both;
                RIDX_POLAR:  rd_val = cfg_q.polar;
                RIDX_ENABLE: rd_val = cfg_q.enable;
                RIDX_RAW:    rd_val = raw_stat;
                RIDX_MASKED: rd_val = raw_stat & cfg_q.enable;
                default:     rd_val = '0;
            endcase
        end
        prdata = (psel && !pwrite) ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense_lvl,
    input  logic both_edge,
    input  logic polar_hi,
    input  logic clr,
    output logic sample,
    output logic raw
);

    edge_state_t st_d, st_q;
    logic        rise;
    logic        fall;
    logic        trig;

    always_comb begin
        rise = st_q.smp & ~st_q.prev;
        fall = ~st_q.smp & st_q.prev;
        if (sense_lvl) begin
            trig = 1'b0;
        end else if (both_edge) begin
            trig = rise | fall;
        end else begin
            trig = polar_hi ? rise : fall;
        end

        st_d      = st_q;
        st_d.smp  = pin;
        st_d.prev = st_q.smp;
        st_d.held = sense_lvl ? 1'b0 : ((st_q.held & ~clr) | trig);

        sample = st_q.smp;
        raw    = sense_lvl ? ~(st_q.smp ^ polar_hi) : st_q.held;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [7:0]        pwdata,
    output logic [7:0]        prdata,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe,
    output logic              irq_out
);

    gpio_cfg_t         cfg;
    logic [GPIO_W-1:0] clr_pulse;
    logic [GPIO_W-1:0] pin_sample;
    logic [GPIO_W-1:0] raw_stat;
    logic [GPIO_W-1:0] masked_stat;

    gpio_reg_file #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .pin_sample (pin_sample),
        .raw_stat   (raw_stat),
        .cfg        (cfg),
        .clr_pulse  (clr_pulse),
        .prdata     (prdata)
    );

    for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
        gpio_edge_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (pin_in[i]),
            .sense_lvl (cfg.sense[i]),
            .both_edge (cfg.both[i]),
            .polar_hi  (cfg.polar[i]),
            .clr       (clr_pulse[i]),
            .sample    (pin_sample[i]),
            .raw       (raw_stat[i])
        );
    end

    always_comb begin
        masked_stat = raw_stat & cfg.enable;
        irq_out     = |masked_stat;
        pin_out     = cfg.dout;
        pin_oe      = cfg.dir;
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [7:0]        pwdata,
    input logic [7:0]        prdata,
    input logic [7:0]        pin_in,
    input logic [7:0]        pin_out,
    input logic [7:0]        pin_oe,
    input logic              irq_out
);

    logic wr_acc;
    logic wr_data;
    assign wr_acc  = psel && penable && pwrite;
    assign wr_data = wr_acc && (paddr[ADDR_W-1:10] == '0);

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == ADDR_W'('h400)) |=> (pin_oe == $past(pwdata))); // R2

    AST_MASK_LIMITS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (((pin_out ^ $past(pin_out)) & ~$past(paddr[9:2])) == 8'h00)); // R3

    AST_INPUT_PIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == 8'h00)); // R4

    AST_IRQ_MATCHES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == ADDR_W'('h418)) |-> (irq_out == (prdata != 8'h00))); // R9

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == ADDR_W'('h41C)) |-> (prdata == 8'h00)); // R10

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;

    localparam logic [11:0] A_DIR  = 12'h400;
    localparam logic [11:0] A_SNS  = 12'h404;
    localparam logic [11:0] A_BOTH = 12'h408;
    localparam logic [11:0] A_POL  = 12'h40C;
    localparam logic [11:0] A_EN   = 12'h410;
    localparam logic [11:0] A_RAW  = 12'h414;
    localparam logic [11:0] A_MSK  = 12'h418;
    localparam logic [11:0] A_CLR  = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [7:0] m_dir = 0, m_sns = 0, m_both = 0, m_pol = 0, m_en = 0, m_dout = 0;
    logic [7:0] m_latch = 0, m_pins = 0;

    gpio_irq_ctrl #(.ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_raw();
        return (m_sns & ~(m_pol ^ m_pins)) | (~m_sns & m_latch);
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] mask);
        return ((m_dir & m_dout) | (~m_dir & m_pins)) & mask;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #2 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    // write through the bus and update the bench model from the requirements
    task automatic mwr(input logic [11:0] a, input logic [7:0] d);
        wr(a, d);
        if (a[11:10] == 2'b00) begin
            m_dout = (m_dout & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
        end else begin
            case (a)
                A_DIR:  m_dir = d;
                A_SNS:  begin m_sns = d; m_latch = m_latch & ~d; end
                A_BOTH: m_both = d;
                A_POL:  m_pol = d;
                A_EN:   m_en = d;
                A_CLR:  m_latch = m_latch & ~(d & ~m_sns);
                default: ;
            endcase
        end
    endtask

    task automatic set_pins(input logic [7:0] v);
        logic [7:0] rise, fall, trig;
        @(negedge clk);
        pin_in = v;
        rise = v & ~m_pins;
        fall = ~v & m_pins;
        trig = (m_both & (rise | fall)) | (~m_both & m_pol & rise) | (~m_both & ~m_pol & fall);
        m_latch = m_latch | (trig & ~m_sns);
        m_pins = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_status(input string tag);
        logic [7:0] v;
        rd(A_RAW, v);
        check({tag, " raw"}, v, exp_raw());
        rd(A_MSK, v);
        check({tag, " masked"}, v, exp_raw() & m_en);
        check({tag, " irq"}, {7'd0, irq_out}, {7'd0, |(exp_raw() & m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'd0, irq_out}, 8'h00);
        for (int k = 0; k < 8; k++) begin
            rd(A_DIR + 12'(k * 4), v);
            check("R1 register", v, 8'h00);
        end

        // R4: write to input pins is dropped
        mwr(12'h3FC, 8'hFF);
        mwr(A_DIR, 8'h0F);
        check("R4 dropped write", pin_out, 8'h00);
        // R2: direction drives output enable
        check("R2 pin_oe", pin_oe, 8'h0F);
        rd(A_DIR, v);
        check("R2 dir readback", v, 8'h0F);

        // R3: masked write and read
        mwr(12'h014, 8'hFF);
        check("R3 masked write", pin_out, 8'h05);
        set_pins(8'hA0);
        rd(12'h3FC, v);
        check("R3 full read", v, 8'hA5);
        rd(12'h0C0, v);
        check("R3 partial read", v, 8'h20);

        // R5/R9: level high on pin 4
        mwr(A_SNS, 8'h10);
        mwr(A_POL, 8'h10);
        mwr(A_EN, 8'h10);
        check("R9 irq low", {7'd0, irq_out}, 8'h00);
        set_pins(8'hB0);
        check_status("R5 level high");
        check("R9 irq high", {7'd0, irq_out}, 8'h01);
        // R8: clear has no effect on a level pin
        mwr(A_CLR, 8'hFF);
        check_status("R8 level clear");
        set_pins(8'hA0);
        check_status("R5 level drop");

        // R6: rising edge on pin 6 latches and stays
        mwr(A_POL, 8'h50);
        mwr(A_EN, 8'h50);
        set_pins(8'hE0);
        set_pins(8'hA0);
        check_status("R6 rising latched");
        mwr(A_CLR, 8'h40);
        check_status("R8 edge cleared");

        // R7: both edges on pin 7 ignore polarity
        mwr(A_BOTH, 8'h80);
        mwr(A_EN, 8'hC0);
        set_pins(8'h20);
        check_status("R7 falling with both");
        mwr(A_CLR, 8'h80);
        set_pins(8'hA0);
        check_status("R7 rising with both");
        mwr(A_CLR, 8'hFF);

        // R8: edge in the same cycle as its clear wins
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = A_CLR; pwdata = 8'h40;
        pin_in = 8'hE0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        m_pins = 8'hE0;
        m_latch = m_latch | 8'h40;
        repeat (2) @(negedge clk);
        rd(A_RAW, v);
        check("R8 edge beats clear", v & 8'h40, 8'h40);
        check_status("R8 after collision");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] r;
            op = int'($urandom_range(0, 6));
            r = 8'($urandom);
            case (op)
                0: begin
                    int k;
                    logic [11:0] a;
                    k = int'($urandom_range(0, 4));
                    a = A_DIR + 12'(k * 4);
                    mwr(a, r);
                    rd(a, v);
                    check("R10 readback", v, r);
                end
                1: begin
                    logic [7:0] mk;
                    mk = 8'($urandom);
                    mwr({2'b00, mk, 2'b00}, r);
                    check("R4 pin_out", pin_out, m_dout);
                    check("R2 pin_oe", pin_oe, m_dir);
                end
                2: begin
                    logic [7:0] mk;
                    mk = 8'($urandom);
                    rd({2'b00, mk, 2'b00}, v);
                    check("R3 data read", v, exp_data(mk));
                end
                3, 4: set_pins(r);
                5: mwr(A_CLR, r);
                default: check_status("R6 R7 R9 random status");
            endcase
        end
        check_status("R9 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule